// File: doc/BRIEF.md
# Outbound Delayed Read Controller

This block accepts read requests from an internal-bus initiator and carries them out on an external bus as delayed transactions. An address is claimed only if it falls inside one of the outbound windows. The direct-access window also claims addresses, but only while software has enabled it. When the single transaction slot is free, a claimed request is captured. The initiator is then told to retry, and a fixed-length read is started on the external side. While that read is outstanding, a core-interface signal tells the surrounding logic not to re-arbitrate for the internal bus.

When the external read ends, normally or with an abort, the hold signal drops and a ready signal rises. The initiator then re-presents the same address and command. It receives one of three results: the buffered data beats in order, a master-abort response, or a target-abort response. Parity-flagged data is passed through with a per-beat error marker. The slot is freed when the result has been handed over. No prefetch is done: the number of Dwords read depends only on the command.

Top module: `odr_ctrl`

## Requirements
- R1: A request is claimed only if its address lies in an outbound window, or in the direct window while `dir_win_en` is 1. An unclaimed request gets response code 0 (none) and starts no external read.
- R2: When the slot is empty, a claimed request is captured. The cycle after the request, the response is 1 (retry). From then on `ext_req` and `cif_hold` are 1, and `ext_addr`/`ext_cmd` show the captured request.
- R3: While an external read is pending, any claimed request gets retry, and the captured `ext_addr`/`ext_cmd` do not change.
- R4: The fetch length `ext_len` is 1, 2 or 4 Dwords for command 0 (plain read), 1 (line read) and 2 (multiple read).
- R5: The initiator's byte enables for the first Dword are forwarded unchanged on `ext_be`.
- R6: After the last external beat, or after an abort, `ext_req` and `cif_hold` fall and `cif_ready` rises.
- R7: A re-presented request whose address and command match the captured ones gets code 2 (data) beats on consecutive cycles, in fetch order. `ib_rlast` is set on the final beat, and in that same cycle `cif_ready` is 0.
- R8: While a result is ready, a claimed request whose address or command differs from the captured one gets retry, and `cif_ready` stays 1.
- R9: External status 1 (master abort) ends the read. The matching re-request then gets code 3 and the slot is freed.
- R10: External status 2 (target abort) ends the read. The matching re-request then gets code 4 in place of the first data phase, and the slot is freed.
- R11: A beat with external status 3 (parity error) is stored and returned with `ib_rperr` set on that beat only.
- R12: Command code 3 is not a read and is never claimed (response 0, no external read).
- R13: If a request arrives in the same cycle as the final external beat, it gets retry, and the following matching request gets the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_win_en | input | 1 | Enables the direct-access window |
| ib_req | input | 1 | Internal-bus read request, one cycle |
| ib_addr | input | AW | Request address |
| ib_cmd | input | 2 | 0 read, 1 line read, 2 multiple read, 3 not a read |
| ib_be | input | DW/8 | First-Dword byte enables |
| ib_rsp | output | 3 | 0 none, 1 retry, 2 data, 3 master abort, 4 target abort |
| ib_rdata | output | DW | Returned data beat |
| ib_rlast | output | 1 | Final data beat |
| ib_rperr | output | 1 | Parity error on this beat |
| cif_hold | output | 1 | Core interface must not request the internal bus |
| cif_ready | output | 1 | Result available; core interface may re-request |
| ext_req | output | 1 | External read outstanding |
| ext_addr | output | AW | External read address |
| ext_cmd | output | 2 | External read command |
| ext_be | output | DW/8 | First-Dword byte enables |
| ext_len | output | 3 | Dwords to fetch |
| ext_valid | input | 1 | External beat valid |
| ext_data | input | DW | External beat data |
| ext_status | input | 2 | 0 okay, 1 master abort, 2 target abort, 3 parity error |

## Verification
Two events can fall in the same cycle: the initiator re-presenting its request, and the final external beat that completes the fetch. The bench drives both on the same clock edge. The rule is that the request is judged against the slot state before that edge, so it must get retry. The next matching request must then get the full data sequence. Busy retries and mismatch retries are provoked the same way: the bench interleaves foreign requests with external beats and checks that the captured external address stays put.

// File: rtl/odr_pkg.sv
package odr_pkg;

  typedef enum logic [1:0] {
    CMD_RD   = 2'd0,
    CMD_LINE = 2'd1,
    CMD_MULT = 2'd2,
    CMD_RSV  = 2'd3
  } ib_cmd_e;

  typedef enum logic [2:0] {
    RSP_NONE   = 3'd0,
    RSP_RETRY  = 3'd1,
    RSP_DATA   = 3'd2,
    RSP_MABORT = 3'd3,
    RSP_TABORT = 3'd4
  } ib_rsp_e;

  typedef enum logic [1:0] {
    XS_OK     = 2'd0,
    XS_MABORT = 2'd1,
    XS_TABORT = 2'd2,
    XS_PERR   = 2'd3
  } ext_sts_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_READY  = 2'd2,
    ST_STREAM = 2'd3
  } odr_state_e;

  // Dwords fetched per command; zero for a non-read command
  function automatic logic [2:0] fetch_dwords(input logic [1:0] cmd);
    case (cmd)
      2'd0:    fetch_dwords = 3'd1;
      2'd1:    fetch_dwords = 3'd2;
      2'd2:    fetch_dwords = 3'd4;
      default: fetch_dwords = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/odr_win_decode.sv
module odr_win_decode #(
  parameter int AW = 32,
  parameter int NWIN = 2,
  parameter int WIN_LOG2 = 16,
  parameter logic [NWIN*AW-1:0] OB_BASES = '0,
  parameter logic [AW-1:0] DIR_BASE = '0,
  parameter int DIR_LOG2 = 20
) (
  input  logic [AW-1:0] addr,
  input  logic          dir_en,
  output logic          hit
);
  localparam int TW = AW - WIN_LOG2;
  localparam int DTW = AW - DIR_LOG2;

  logic [NWIN-1:0] ob_hit;
  logic            dir_hit;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign ob_hit[w] = (addr[AW-1:WIN_LOG2] == OB_BASES[w*AW+WIN_LOG2 +: TW]);
  end

  assign dir_hit = dir_en && (addr[AW-1:DIR_LOG2] == DIR_BASE[AW-1 -: DTW]);
  assign hit = (|ob_hit) || dir_hit;
endmodule

// File: rtl/odr_beat_store.sv
module odr_beat_store #(
  parameter int DW = 32,
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic                     wr_perr,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data,
  output logic                     rd_perr
);
  logic [DW-1:0]    mem_q  [DEPTH];
  logic [DEPTH-1:0] perr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      perr_q <= '0;
    end else if (wr_en) begin
      mem_q[wr_idx]  <= wr_data;
      perr_q[wr_idx] <= wr_perr;
    end
  end

  assign rd_data = mem_q[rd_idx];
  assign rd_perr = perr_q[rd_idx];
endmodule

// File: rtl/odr_ctrl.sv
module odr_ctrl #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NWIN = 2,
  parameter int WIN_LOG2 = 16,
  parameter logic [NWIN*AW-1:0] OB_BASES = {32'h9000_0000, 32'h8000_0000},
  parameter logic [AW-1:0] DIR_BASE = 32'h0000_0000,
  parameter int DIR_LOG2 = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dir_win_en,
  input  logic            ib_req,
  input  logic [AW-1:0]   ib_addr,
  input  logic [1:0]      ib_cmd,
  input  logic [DW/8-1:0] ib_be,
  output logic [2:0]      ib_rsp,
  output logic [DW-1:0]   ib_rdata,
  output logic            ib_rlast,
  output logic            ib_rperr,
  output logic            cif_hold,
  output logic            cif_ready,
  output logic            ext_req,
  output logic [AW-1:0]   ext_addr,
  output logic [1:0]      ext_cmd,
  output logic [DW/8-1:0] ext_be,
  output logic [2:0]      ext_len,
  input  logic            ext_valid,
  input  logic [DW-1:0]   ext_data,
  input  logic [1:0]      ext_status
);
  import odr_pkg::*;

  localparam int MAXB = 4;
  localparam int BW = $clog2(MAXB);
  localparam int BEW = DW / 8;

  odr_state_e      state_q;
  logic [AW-1:0]   q_addr;
  logic [1:0]      q_cmd;
  logic [BEW-1:0]  q_be;
  logic [2:0]      q_len;
  ext_sts_e        q_abort;
  logic [BW-1:0]   wcnt_q, rcnt_q;

  ib_rsp_e         rsp_q;
  logic [DW-1:0]   rdata_q;
  logic            rlast_q, rperr_q;

  // Named internal events
  logic win_hit, claim, match, beat_in, beat_abort, beat_final, store_wr;
  logic [BW-1:0] rd_idx;
  logic [DW-1:0] st_data;
  logic st_perr;
  ext_sts_e xs;

  assign xs = ext_sts_e'(ext_status);

  odr_win_decode #(
    .AW(AW), .NWIN(NWIN), .WIN_LOG2(WIN_LOG2), .OB_BASES(OB_BASES),
    .DIR_BASE(DIR_BASE), .DIR_LOG2(DIR_LOG2)
  ) u_dec (
    .addr(ib_addr), .dir_en(dir_win_en), .hit(win_hit)
  );

  assign claim      = ib_req && win_hit && (ib_cmd != CMD_RSV);
  assign match      = claim && (ib_addr == q_addr) && (ib_cmd == q_cmd);
  assign beat_in    = (state_q == ST_FETCH) && ext_valid;
  assign beat_abort = beat_in && ((xs == XS_MABORT) || (xs == XS_TABORT));
  assign beat_final = beat_in && ({1'b0, wcnt_q} == q_len - 3'd1);
  assign store_wr   = beat_in && !beat_abort;
  assign rd_idx     = (state_q == ST_READY) ? '0 : rcnt_q;

  odr_beat_store #(.DW(DW), .DEPTH(MAXB)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(store_wr), .wr_idx(wcnt_q), .wr_data(ext_data),
    .wr_perr(xs == XS_PERR),
    .rd_idx(rd_idx), .rd_data(st_data), .rd_perr(st_perr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      q_addr  <= '0;
      q_cmd   <= '0;
      q_be    <= '0;
      q_len   <= '0;
      q_abort <= XS_OK;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
      rsp_q   <= RSP_NONE;
      rdata_q <= '0;
      rlast_q <= 1'b0;
      rperr_q <= 1'b0;
    end else begin
      rsp_q   <= RSP_NONE;
      rdata_q <= '0;
      rlast_q <= 1'b0;
      rperr_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (claim) begin
            q_addr  <= ib_addr;
            q_cmd   <= ib_cmd;
            q_be    <= ib_be;
            q_len   <= fetch_dwords(ib_cmd);
            q_abort <= XS_OK;
            wcnt_q  <= '0;
            rsp_q   <= RSP_RETRY;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (claim) rsp_q <= RSP_RETRY;
          if (beat_abort) begin
            q_abort <= xs;
            state_q <= ST_READY;
          end else if (beat_in) begin
            wcnt_q <= wcnt_q + 1'b1;
            if (beat_final) state_q <= ST_READY;
          end
        end
        ST_READY: begin
          if (match) begin
            if (q_abort == XS_MABORT) begin
              rsp_q   <= RSP_MABORT;
              state_q <= ST_IDLE;
            end else if (q_abort == XS_TABORT) begin
              rsp_q   <= RSP_TABORT;
              state_q <= ST_IDLE;
            end else begin
              rsp_q   <= RSP_DATA;
              rdata_q <= st_data;
              rperr_q <= st_perr;
              rlast_q <= (q_len == 3'd1);
              rcnt_q  <= 1;
              state_q <= (q_len == 3'd1) ? ST_IDLE : ST_STREAM;
            end
          end else if (claim) begin
            rsp_q <= RSP_RETRY;
          end
        end
        default: begin
          rsp_q   <= RSP_DATA;
          rdata_q <= st_data;
          rperr_q <= st_perr;
          rcnt_q  <= rcnt_q + 1'b1;
          if ({1'b0, rcnt_q} == q_len - 3'd1) begin
            rlast_q <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign ib_rsp    = rsp_q;
  assign ib_rdata  = rdata_q;
  assign ib_rlast  = rlast_q;
  assign ib_rperr  = rperr_q;
  assign ext_req   = (state_q == ST_FETCH);
  assign cif_hold  = (state_q == ST_FETCH);
  assign cif_ready = (state_q == ST_READY) || (state_q == ST_STREAM);
  assign ext_addr  = q_addr;
  assign ext_cmd   = q_cmd;
  assign ext_be    = q_be;
  assign ext_len   = q_len;
endmodule

// File: rtl/odr_ctrl_chk.sv
module odr_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    ib_rsp,
  input logic          ib_rlast,
  input logic          ib_rperr,
  input logic          cif_hold,
  input logic          cif_ready,
  input logic          ext_req,
  input logic [AW-1:0] ext_addr,
  input logic [1:0]    ext_cmd,
  input logic [2:0]    ext_len
);
  // R2: starting an external read coincides with a retry response
  a_r2_start_retries: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_req) |-> (ib_rsp == 3'd1));

  // R3: captured request stable while the read is outstanding
  a_r3_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && $past(ext_req)) |-> ($stable(ext_addr) && $stable(ext_cmd)));

  // R4: fetch length is a single power of two while reading
  a_r4_len_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> ($countones(ext_len) == 1));

  // R6: hold and ready never overlap
  a_r6_hold_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cif_hold && cif_ready));

  // R6: a falling external read leaves the result ready
  a_r6_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_req) |-> cif_ready);

  // R7: final data beat frees the slot
  a_r7_last_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_rsp == 3'd2 && ib_rlast) |-> !cif_ready);

  // R9 / R10: abort responses free the slot
  a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_rsp == 3'd3 || ib_rsp == 3'd4) |-> (!cif_ready && !ext_req));

  // R11: parity marker only accompanies data
  a_r11_perr_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    ib_rperr |-> (ib_rsp == 3'd2));
endmodule

bind odr_ctrl odr_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/odr_ctrl_tb.sv
module odr_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_win_en = 1'b0;
  logic        ib_req = 1'b0;
  logic [31:0] ib_addr = '0;
  logic [1:0]  ib_cmd = '0;
  logic [3:0]  ib_be = '0;
  logic [2:0]  ib_rsp;
  logic [31:0] ib_rdata;
  logic        ib_rlast, ib_rperr, cif_hold, cif_ready, ext_req;
  logic [31:0] ext_addr;
  logic [1:0]  ext_cmd;
  logic [3:0]  ext_be;
  logic [2:0]  ext_len;
  logic        ext_valid = 1'b0;
  logic [31:0] ext_data = '0;
  logic [1:0]  ext_status = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  odr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .dir_win_en(dir_win_en),
    .ib_req(ib_req), .ib_addr(ib_addr), .ib_cmd(ib_cmd), .ib_be(ib_be),
    .ib_rsp(ib_rsp), .ib_rdata(ib_rdata), .ib_rlast(ib_rlast), .ib_rperr(ib_rperr),
    .cif_hold(cif_hold), .cif_ready(cif_ready),
    .ext_req(ext_req), .ext_addr(ext_addr), .ext_cmd(ext_cmd), .ext_be(ext_be),
    .ext_len(ext_len), .ext_valid(ext_valid), .ext_data(ext_data),
    .ext_status(ext_status)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] beat_val(input logic [31:0] a, input int i);
    return a ^ (32'h1111_1111 * (i + 1)) ^ 32'h00A5_0000;
  endfunction

  task automatic ib_issue(input logic [31:0] a, input logic [1:0] c, input logic [3:0] b);
    ib_req = 1'b1; ib_addr = a; ib_cmd = c; ib_be = b;
    @(negedge clk);
    ib_req = 1'b0;
  endtask

  task automatic ext_beat(input logic [31:0] d, input logic [1:0] s);
    ext_valid = 1'b1; ext_data = d; ext_status = s;
    @(negedge clk);
    ext_valid = 1'b0;
  endtask

  // Full delayed read; sts holds 2-bit external status per beat
  task automatic do_read(input logic [31:0] a, input logic [1:0] c,
                         input logic [3:0] b, input logic [7:0] sts);
    int n;
    int term;
    n = 1 << c;
    term = 0;
    ib_issue(a, c, b);
    chk("R2 retry on capture", ib_rsp, 1);
    chk("R2 ext_req", ext_req, 1);
    chk("R2 hold", cif_hold, 1);
    chk("R2 ext_addr", ext_addr, a);
    chk("R4 length", ext_len, n);
    chk("R5 byte enables", ext_be, b);
    for (int i = 0; i < n; i++) begin
      ext_beat(beat_val(a, i), sts[2*i +: 2]);
      if (sts[2*i +: 2] == 2'd1 || sts[2*i +: 2] == 2'd2) begin
        term = sts[2*i +: 2];
        break;
      end
    end
    chk("R6 ext_req low", ext_req, 0);
    chk("R6 hold low", cif_hold, 0);
    chk("R6 ready", cif_ready, 1);
    ib_issue(a, c, b);
    if (term == 1) begin
      chk("R9 master abort", ib_rsp, 3);
      chk("R9 slot freed", cif_ready, 0);
    end else if (term == 2) begin
      chk("R10 target abort", ib_rsp, 4);
      chk("R10 slot freed", cif_ready, 0);
    end else begin
      for (int i = 0; i < n; i++) begin
        if (i > 0) @(negedge clk);
        chk("R7 data code", ib_rsp, 2);
        chk("R7 data value", ib_rdata, beat_val(a, i));
        chk("R7 last flag", ib_rlast, (i == n - 1));
        chk("R11 parity flag", ib_rperr, (sts[2*i +: 2] == 2'd3));
      end
      chk("R7 slot freed", cif_ready, 0);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset ready", cif_ready, 0);
    chk("R2 reset ext_req", ext_req, 0);
    chk("R2 reset rsp", ib_rsp, 0);

    // R1: outside all windows
    ib_issue(32'h4000_0010, 2'd0, 4'hF);
    chk("R1 unclaimed rsp", ib_rsp, 0);
    chk("R1 no ext read", ext_req, 0);
    // R1: direct window disabled
    ib_issue(32'h0000_1000, 2'd0, 4'hF);
    chk("R1 direct disabled rsp", ib_rsp, 0);
    chk("R1 direct disabled ext", ext_req, 0);
    // R12: non-read command inside a window
    ib_issue(32'h8000_0040, 2'd3, 4'hF);
    chk("R12 reserved rsp", ib_rsp, 0);
    chk("R12 no ext read", ext_req, 0);

    // Sweep commands, byte enables and both outbound windows
    for (int c = 0; c < 3; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic [3:0] b;
        b = (k == 0) ? 4'hF : (k == 1) ? 4'h1 : (k == 2) ? 4'h6 : 4'h8;
        a = ((k % 2) ? 32'h9000_0000 : 32'h8000_0000) + 32'(c * 256 + k * 16);
        do_read(a, 2'(c), b, 8'h00);
      end
    end

    // R1: direct window enabled
    dir_win_en = 1'b1;
    do_read(32'h0000_2000, 2'd2, 4'h3, 8'h00);
    dir_win_en = 1'b0;

    // R11: parity on beats 1 and 3
    do_read(32'h8000_0300, 2'd2, 4'hF, 8'b11_00_11_00);
    // R9: master abort first beat, line read
    do_read(32'h9000_0400, 2'd1, 4'hF, 8'b00_00_00_01);
    // R10: target abort on beat 1 of a multiple read
    do_read(32'h8000_0500, 2'd2, 4'hF, 8'b00_00_10_00);
    // R10: target abort on a single read
    do_read(32'h9000_0600, 2'd0, 4'h2, 8'b00_00_00_10);

    // R3 / R13 / R8 sequence
    a = 32'h8000_0700;
    ib_issue(a, 2'd2, 4'hF);
    chk("R2 capture", ib_rsp, 1);
    ext_beat(beat_val(a, 0), 2'd0);
    ib_issue(32'h9000_0800, 2'd0, 4'hF);
    chk("R3 busy retry", ib_rsp, 1);
    chk("R3 addr kept", ext_addr, a);
    chk("R3 cmd kept", ext_cmd, 2);
    ext_beat(beat_val(a, 1), 2'd0);
    ext_beat(beat_val(a, 2), 2'd0);
    // final beat and re-presentation in the same cycle
    ext_valid = 1'b1; ext_data = beat_val(a, 3); ext_status = 2'd0;
    ib_req = 1'b1; ib_addr = a; ib_cmd = 2'd2; ib_be = 4'hF;
    @(negedge clk);
    ext_valid = 1'b0; ib_req = 1'b0;
    chk("R13 coincident retry", ib_rsp, 1);
    chk("R13 ready after", cif_ready, 1);
    ib_issue(a, 2'd1, 4'hF);
    chk("R8 cmd mismatch retry", ib_rsp, 1);
    chk("R8 ready kept", cif_ready, 1);
    ib_issue(a + 32'h4, 2'd2, 4'hF);
    chk("R8 addr mismatch retry", ib_rsp, 1);
    chk("R8 ready kept 2", cif_ready, 1);
    ib_issue(a, 2'd2, 4'hF);
    for (int i = 0; i < 4; i++) begin
      if (i > 0) @(negedge clk);
      chk("R13 data code", ib_rsp, 2);
      chk("R13 data value", ib_rdata, beat_val(a, i));
      chk("R7 last", ib_rlast, (i == 3));
    end
    chk("R7 freed", cif_ready, 0);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule